// File: doc/BRIEF.md
# Coprocessor Reconfiguration Controller

This block moves partial configuration images from an external byte-wide memory into a device configuration port, on behalf of two bus masters. A host link works with the block while `mode_load` is high. It stores image bytes into the memory and records, for each numbered image slot, where the image starts and how many bytes it holds. Once the application is running, `mode_load` is low. The embedded processor then issues commands that either fill a reconfigurable area with the image of a chosen slot or release that area.

A fill command is non-blocking. The block reads the image bytes one at a time, in ascending address order, and offers each byte on a valid/ready sink tagged with the target area. It raises a sticky done flag and an interrupt once the final byte has been taken, so the processor can carry on with other work during the transfer. Each area has an isolation enable that is high only while the area holds a complete image. A release command clears the enable and streams nothing. While a transfer is active, any further command is refused and raises an error flag. Host writes to the memory are also refused during a transfer. `N_AREAS` and `N_SLOTS` are expected to be powers of two.

Top module: `reconf_ctrl`

## Requirements
- R1: After reset, busy, done, error, irq, every isolation enable, cfg_valid and mem_we are all 0.
- R2: A host memory write goes through (host_mem_ok and mem_we high in the same cycle, at host_mem_addr) only when mode_load is 1 and no transfer is active. In any other case host_mem_ok and mem_we stay 0 and the memory keeps its content.
- R3: Slot table writes (start address, byte length per slot) take effect only when mode_load is 1 and the block is idle. A table write made in run mode leaves the next transfer of that slot unchanged.
- R4: A fill command is written as cpu_cmd with bit 0 = area, bits 2:1 = slot and bit 3 = 0. When accepted, it streams exactly the slot's length in bytes, starting at the slot's start address and rising by one address per byte. Each byte appears on cfg_data with cfg_area equal to the target area, and cfg_data stays stable while cfg_valid is high and cfg_ready is low.
- R5: In the cycle after the last byte is taken, busy is 0, done and irq are 1, the target area's isolation enable is 1, and its area_slot field holds the slot.
- R6: From the cycle after an accepted fill until completion, busy is 1 and the target area's isolation enable is 0.
- R7: A command issued while busy or while mode_load is 1 is rejected. error becomes 1 on the next cycle, nothing is queued, and areas and the ongoing stream are unaffected.
- R8: A release command (bit 3 of cpu_cmd = 1, bit 0 = area) sets that area's isolation enable to 0 on the next cycle. It produces no cfg_valid, does not set busy and does not set done.
- R9: Writing cpu_clr with bit 0 = 1 clears done and irq, and bit 1 = 1 clears error. A 0 bit leaves its flag unchanged.
- R10: A fill of a slot whose length is 0 completes at once. The next cycle shows done = 1, busy = 0 and the area loaded with that slot, and no byte is streamed.
- R11: Commands to one area never change the isolation enable or slot of another area.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_load | input | 1 | 1 = host load mode, 0 = run mode |
| host_mem_wr | input | 1 | Host memory byte write strobe |
| host_mem_addr | input | ADDR_W | Host memory write address |
| host_mem_data | input | 8 | Host memory write byte |
| host_mem_ok | output | 1 | Host memory write accepted this cycle |
| host_tbl_wr | input | 1 | Host slot table write strobe |
| host_tbl_slot | input | SLOT_W | Slot being described |
| host_tbl_start | input | ADDR_W | Image start address |
| host_tbl_len | input | LEN_W | Image length in bytes |
| cpu_cmd_wr | input | 1 | Processor command strobe |
| cpu_cmd | input | CMD_W | {release, slot, area} |
| cpu_clr_wr | input | 1 | Processor status clear strobe |
| cpu_clr | input | 2 | Bit 0 clears done, bit 1 clears error |
| st_busy | output | 1 | Transfer in progress |
| st_done | output | 1 | Sticky completion flag |
| st_error | output | 1 | Sticky rejected-command flag |
| irq | output | 1 | Completion interrupt |
| iso_en | output | N_AREAS | Per-area isolation enable (area holds an image) |
| area_slot | output | N_AREAS*SLOT_W | Slot loaded in each area |
| mem_we | output | 1 | Configuration memory write enable |
| mem_re | output | 1 | Configuration memory read enable |
| mem_addr | output | ADDR_W | Configuration memory address |
| mem_wdata | output | 8 | Configuration memory write byte |
| mem_rdata | input | 8 | Read byte, valid one cycle after mem_re |
| cfg_valid | output | 1 | Configuration byte valid |
| cfg_ready | input | 1 | Configuration port accepts byte |
| cfg_data | output | 8 | Configuration byte |
| cfg_area | output | AREA_W | Area the byte is destined for |

## Verification
The bench builds the block with an 8-bit address and 8-bit lengths, four slots and two areas. At that size a 256-byte memory model covers the whole address space, and every slot and area can be named in a short vector table. Short images (0, 1, 5 and 9 bytes) make the empty-image path and the single-byte last-beat case reachable in a few cycles. Sparse ready patterns keep a transfer open long enough to issue commands and host writes against it.

// File: rtl/reconf_pkg.sv
package reconf_pkg;

  typedef enum logic [1:0] {
    XF_IDLE  = 2'd0,
    XF_READ  = 2'd1,
    XF_LATCH = 2'd2,
    XF_SEND  = 2'd3
  } xfer_state_e;

  localparam int CLR_DONE_BIT = 0;
  localparam int CLR_ERR_BIT  = 1;

  // clock cycles per streamed byte when the sink is always ready
  localparam int CYCLES_PER_BYTE = 3;

  function automatic int unsigned best_case_cycles(input int unsigned nbytes);
    return nbytes * CYCLES_PER_BYTE;
  endfunction

endpackage

// File: rtl/rc_slot_table.sv
module rc_slot_table #(
  parameter int N_SLOTS = 4,
  parameter int ADDR_W  = 16,
  parameter int LEN_W   = 16,
  localparam int SLOT_W = $clog2(N_SLOTS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [SLOT_W-1:0] wr_slot,
  input  logic [ADDR_W-1:0] wr_start,
  input  logic [LEN_W-1:0]  wr_len,
  input  logic [SLOT_W-1:0] rd_slot,
  output logic [ADDR_W-1:0] rd_start,
  output logic [LEN_W-1:0]  rd_len
);

  logic [ADDR_W-1:0] starts [N_SLOTS];
  logic [LEN_W-1:0]  lens   [N_SLOTS];

  for (genvar s = 0; s < N_SLOTS; s++) begin : g_slot
    logic [ADDR_W-1:0] r_start;
    logic [LEN_W-1:0]  r_len;
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        r_start <= '0;
        r_len   <= '0;
      end else if (wr_en && wr_slot == SLOT_W'(s)) begin
        r_start <= wr_start;
        r_len   <= wr_len;
      end
    end
    assign starts[s] = r_start;
    assign lens[s]   = r_len;
  end

  assign rd_start = starts[rd_slot];
  assign rd_len   = lens[rd_slot];

endmodule

// File: rtl/rc_area_map.sv
module rc_area_map #(
  parameter int N_AREAS = 2,
  parameter int SLOT_W  = 2,
  localparam int AREA_W = $clog2(N_AREAS)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      wr_en,
  input  logic                      wr_full,
  input  logic [AREA_W-1:0]         wr_idx,
  input  logic [SLOT_W-1:0]         wr_slot,
  output logic [N_AREAS-1:0]        full,
  output logic [N_AREAS*SLOT_W-1:0] slot_flat
);

  for (genvar a = 0; a < N_AREAS; a++) begin : g_area
    logic              r_full;
    logic [SLOT_W-1:0] r_slot;
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        r_full <= 1'b0;
        r_slot <= '0;
      end else if (wr_en && wr_idx == AREA_W'(a)) begin
        r_full <= wr_full;
        if (wr_full) r_slot <= wr_slot;
      end
    end
    assign full[a] = r_full;
    assign slot_flat[a*SLOT_W +: SLOT_W] = r_slot;
  end

endmodule

// File: rtl/rc_streamer.sv
module rc_streamer
  import reconf_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int LEN_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic [LEN_W-1:0]  start_len,
  output logic              mem_re,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic [7:0]        mem_rdata,
  output logic              cfg_valid,
  input  logic              cfg_ready,
  output logic [7:0]        cfg_data,
  output logic              busy,
  output logic              fin
);

  xfer_state_e       state;
  logic [ADDR_W-1:0] ptr;
  logic [LEN_W-1:0]  left;
  logic [7:0]        byte_q;

  function automatic logic is_last(input logic [LEN_W-1:0] remaining);
    return remaining == LEN_W'(1);
  endfunction

  logic beat;
  assign beat = (state == XF_SEND) && cfg_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= XF_IDLE;
      ptr    <= '0;
      left   <= '0;
      byte_q <= '0;
    end else begin
      unique case (state)
        XF_IDLE: if (start && start_len != '0) begin
          ptr   <= start_addr;
          left  <= start_len;
          state <= XF_READ;
        end
        XF_READ:  state <= XF_LATCH;
        XF_LATCH: begin
          byte_q <= mem_rdata;
          state  <= XF_SEND;
        end
        XF_SEND: if (beat) begin
          ptr   <= ptr + ADDR_W'(1);
          left  <= left - LEN_W'(1);
          state <= is_last(left) ? XF_IDLE : XF_READ;
        end
        default: state <= XF_IDLE;
      endcase
    end
  end

  assign mem_re    = (state == XF_READ);
  assign mem_addr  = ptr;
  assign cfg_valid = (state == XF_SEND);
  assign cfg_data  = byte_q;
  assign busy      = (state != XF_IDLE);
  assign fin       = beat && is_last(left);

endmodule

// File: rtl/reconf_ctrl.sv
module reconf_ctrl
  import reconf_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int LEN_W   = 16,
  parameter int N_SLOTS = 4,
  parameter int N_AREAS = 2,
  localparam int SLOT_W = $clog2(N_SLOTS),
  localparam int AREA_W = $clog2(N_AREAS),
  localparam int CMD_W  = AREA_W + SLOT_W + 1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      mode_load,
  input  logic                      host_mem_wr,
  input  logic [ADDR_W-1:0]         host_mem_addr,
  input  logic [7:0]                host_mem_data,
  output logic                      host_mem_ok,
  input  logic                      host_tbl_wr,
  input  logic [SLOT_W-1:0]         host_tbl_slot,
  input  logic [ADDR_W-1:0]         host_tbl_start,
  input  logic [LEN_W-1:0]          host_tbl_len,
  input  logic                      cpu_cmd_wr,
  input  logic [CMD_W-1:0]          cpu_cmd,
  input  logic                      cpu_clr_wr,
  input  logic [1:0]                cpu_clr,
  output logic                      st_busy,
  output logic                      st_done,
  output logic                      st_error,
  output logic                      irq,
  output logic [N_AREAS-1:0]        iso_en,
  output logic [N_AREAS*SLOT_W-1:0] area_slot,
  output logic                      mem_we,
  output logic                      mem_re,
  output logic [ADDR_W-1:0]         mem_addr,
  output logic [7:0]                mem_wdata,
  input  logic [7:0]                mem_rdata,
  output logic                      cfg_valid,
  input  logic                      cfg_ready,
  output logic [7:0]                cfg_data,
  output logic [AREA_W-1:0]         cfg_area
);

  // command decode
  logic              cmd_drop;
  logic [AREA_W-1:0] cmd_area;
  logic [SLOT_W-1:0] cmd_slot;
  assign cmd_area = cpu_cmd[AREA_W-1:0];
  assign cmd_slot = cpu_cmd[AREA_W +: SLOT_W];
  assign cmd_drop = cpu_cmd[CMD_W-1];

  // named internal events
  logic xfer_busy, xfer_fin;
  logic host_gate, cmd_accept, cmd_reject;
  logic sel_go, drop_go, zero_go, stream_go;

  logic [ADDR_W-1:0] tbl_start;
  logic [LEN_W-1:0]  tbl_len;
  logic [ADDR_W-1:0] strm_addr;
  logic [AREA_W-1:0] tgt_area;
  logic [SLOT_W-1:0] tgt_slot;
  logic              done_q, err_q;

  function automatic logic may_command(input logic busy, input logic load);
    return !busy && !load;
  endfunction

  assign host_gate  = mode_load && !xfer_busy;
  assign cmd_accept = cpu_cmd_wr && may_command(xfer_busy, mode_load);
  assign cmd_reject = cpu_cmd_wr && !cmd_accept;
  assign sel_go     = cmd_accept && !cmd_drop;
  assign drop_go    = cmd_accept && cmd_drop;
  assign zero_go    = sel_go && (tbl_len == '0);
  assign stream_go  = sel_go && (tbl_len != '0);

  rc_slot_table #(.N_SLOTS(N_SLOTS), .ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_table (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (host_tbl_wr && host_gate),
    .wr_slot  (host_tbl_slot),
    .wr_start (host_tbl_start),
    .wr_len   (host_tbl_len),
    .rd_slot  (cmd_slot),
    .rd_start (tbl_start),
    .rd_len   (tbl_len)
  );

  rc_streamer #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_stream (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (stream_go),
    .start_addr (tbl_start),
    .start_len  (tbl_len),
    .mem_re     (mem_re),
    .mem_addr   (strm_addr),
    .mem_rdata  (mem_rdata),
    .cfg_valid  (cfg_valid),
    .cfg_ready  (cfg_ready),
    .cfg_data   (cfg_data),
    .busy       (xfer_busy),
    .fin        (xfer_fin)
  );

  // area bookkeeping: at most one writer per cycle (fin only while busy,
  // commands only while idle)
  logic              map_wr, map_full;
  logic [AREA_W-1:0] map_idx;
  logic [SLOT_W-1:0] map_slot;
  assign map_wr   = stream_go || drop_go || zero_go || xfer_fin;
  assign map_full = zero_go || xfer_fin;
  assign map_idx  = xfer_fin ? tgt_area : cmd_area;
  assign map_slot = xfer_fin ? tgt_slot : cmd_slot;

  rc_area_map #(.N_AREAS(N_AREAS), .SLOT_W(SLOT_W)) u_areas (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (map_wr),
    .wr_full   (map_full),
    .wr_idx    (map_idx),
    .wr_slot   (map_slot),
    .full      (iso_en),
    .slot_flat (area_slot)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tgt_area <= '0;
      tgt_slot <= '0;
    end else if (stream_go) begin
      tgt_area <= cmd_area;
      tgt_slot <= cmd_slot;
    end
  end

  // sticky flags: a new event wins over a clear in the same cycle
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      if (xfer_fin || zero_go)                       done_q <= 1'b1;
      else if (cpu_clr_wr && cpu_clr[CLR_DONE_BIT])  done_q <= 1'b0;
      if (cmd_reject)                                err_q  <= 1'b1;
      else if (cpu_clr_wr && cpu_clr[CLR_ERR_BIT])   err_q  <= 1'b0;
    end
  end

  assign st_busy  = xfer_busy;
  assign st_done  = done_q;
  assign st_error = err_q;
  assign irq      = done_q;

  // shared memory port
  assign host_mem_ok = host_mem_wr && host_gate;
  assign mem_we      = host_mem_ok;
  assign mem_wdata   = host_mem_data;
  assign mem_addr    = xfer_busy ? strm_addr : host_mem_addr;
  assign cfg_area    = tgt_area;

endmodule

// File: rtl/reconf_ctrl_checker.sv
module reconf_ctrl_checker #(
  parameter int N_AREAS = 2,
  parameter int AREA_W  = 1,
  parameter int CMD_W   = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic               mode_load,
  input logic               cpu_cmd_wr,
  input logic [CMD_W-1:0]   cpu_cmd,
  input logic               cpu_clr_wr,
  input logic [1:0]         cpu_clr,
  input logic               st_busy,
  input logic               st_done,
  input logic               st_error,
  input logic               irq,
  input logic [N_AREAS-1:0] iso_en,
  input logic               mem_we,
  input logic               cfg_valid,
  input logic               cfg_ready,
  input logic [7:0]         cfg_data,
  input logic [AREA_W-1:0]  cfg_area,
  input logic               xfer_fin
);

  AST_CFG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_valid && !cfg_ready |=> cfg_valid && $stable(cfg_data) && $stable(cfg_area)); // R4

  AST_NO_HOST_WRITE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    st_busy |-> !mem_we); // R2

  AST_FIN_RAISES_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_fin |=> st_done && irq && !st_busy && iso_en[$past(cfg_area)]); // R5

  AST_STREAM_ISOLATED: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_valid |-> st_busy && !iso_en[cfg_area]); // R6

  AST_BUSY_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_cmd_wr && (st_busy || mode_load) |=> st_error); // R7

  AST_RELEASE_AREA: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_cmd_wr && cpu_cmd[CMD_W-1] && !st_busy && !mode_load
    |=> !iso_en[$past(cpu_cmd[AREA_W-1:0])] && !st_busy); // R8

  AST_CLEAR_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_clr_wr && cpu_clr[0] && !xfer_fin && !cpu_cmd_wr |=> !st_done && !irq); // R9

endmodule

bind reconf_ctrl reconf_ctrl_checker #(
  .N_AREAS (N_AREAS),
  .AREA_W  (AREA_W),
  .CMD_W   (CMD_W)
) u_checker (
  .clk        (clk),
  .rst_n      (rst_n),
  .mode_load  (mode_load),
  .cpu_cmd_wr (cpu_cmd_wr),
  .cpu_cmd    (cpu_cmd),
  .cpu_clr_wr (cpu_clr_wr),
  .cpu_clr    (cpu_clr),
  .st_busy    (st_busy),
  .st_done    (st_done),
  .st_error   (st_error),
  .irq        (irq),
  .iso_en     (iso_en),
  .mem_we     (mem_we),
  .cfg_valid  (cfg_valid),
  .cfg_ready  (cfg_ready),
  .cfg_data   (cfg_data),
  .cfg_area   (cfg_area),
  .xfer_fin   (xfer_fin)
);

// File: tb/test_reconf_ctrl.sv
module test_reconf_ctrl;
  localparam int ADDR_W = 8;
  localparam int LEN_W  = 8;
  localparam int N_SLOTS = 4;
  localparam int N_AREAS = 2;
  localparam int SLOT_W = 2;
  localparam int AREA_W = 1;
  localparam int CMD_W  = 4;

  // slot layout used by the bench
  localparam logic [7:0] S_START [4] = '{8'h10, 8'h40, 8'h80, 8'hC0};
  localparam int         S_LEN   [4] = '{5, 1, 9, 0};

  // vectors: {area, slot, ready pattern}
  localparam int NV = 4;
  localparam logic [10:0] VEC [NV] = '{
    {1'b0, 2'd0, 8'b1111_1111},
    {1'b1, 2'd2, 8'b1010_0110},
    {1'b0, 2'd1, 8'b0001_0001},
    {1'b1, 2'd0, 8'b0111_1110}
  };

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n = 1'b0, mode_load = 1'b1;
  logic host_mem_wr = 0, host_tbl_wr = 0, cpu_cmd_wr = 0, cpu_clr_wr = 0;
  logic [ADDR_W-1:0] host_mem_addr = '0, host_tbl_start = '0;
  logic [7:0] host_mem_data = '0;
  logic [SLOT_W-1:0] host_tbl_slot = '0;
  logic [LEN_W-1:0] host_tbl_len = '0;
  logic [CMD_W-1:0] cpu_cmd = '0;
  logic [1:0] cpu_clr = '0;
  logic host_mem_ok, st_busy, st_done, st_error, irq;
  logic [N_AREAS-1:0] iso_en;
  logic [N_AREAS*SLOT_W-1:0] area_slot;
  logic mem_we, mem_re;
  logic [ADDR_W-1:0] mem_addr;
  logic [7:0] mem_wdata, mem_rdata;
  logic cfg_valid, cfg_ready = 1'b0;
  logic [7:0] cfg_data;
  logic [AREA_W-1:0] cfg_area;

  reconf_ctrl #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .N_SLOTS(N_SLOTS), .N_AREAS(N_AREAS)) i_reconf_ctrl (
    .clk(clk), .rst_n(rst_n), .mode_load(mode_load),
    .host_mem_wr(host_mem_wr), .host_mem_addr(host_mem_addr), .host_mem_data(host_mem_data),
    .host_mem_ok(host_mem_ok), .host_tbl_wr(host_tbl_wr), .host_tbl_slot(host_tbl_slot),
    .host_tbl_start(host_tbl_start), .host_tbl_len(host_tbl_len),
    .cpu_cmd_wr(cpu_cmd_wr), .cpu_cmd(cpu_cmd), .cpu_clr_wr(cpu_clr_wr), .cpu_clr(cpu_clr),
    .st_busy(st_busy), .st_done(st_done), .st_error(st_error), .irq(irq),
    .iso_en(iso_en), .area_slot(area_slot),
    .mem_we(mem_we), .mem_re(mem_re), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .cfg_valid(cfg_valid), .cfg_ready(cfg_ready),
    .cfg_data(cfg_data), .cfg_area(cfg_area)
  );

  // configuration memory model, one cycle read latency
  logic [7:0] ram [256];
  logic [7:0] ram_q = '0;
  always @(posedge clk) begin
    if (mem_we) ram[mem_addr] <= mem_wdata;
    if (mem_re) ram_q <= ram[mem_addr];
  end
  assign mem_rdata = ram_q;

  // configuration sink monitor
  logic [7:0] rdy_pat = 8'hFF;
  int ph = 0, ngot = 0, nvalid = 0, nstall = 0, narea_bad = 0;
  logic [7:0] got [32];
  bit hold = 0;
  logic [7:0] hold_d = '0;
  logic [AREA_W-1:0] want_area = '0;
  always @(negedge clk) begin
    if (hold && (!cfg_valid || cfg_data != hold_d)) nstall++;
    cfg_ready = rdy_pat[ph % 8];
    ph++;
    if (cfg_valid) begin
      nvalid++;
      if (cfg_area != want_area) narea_bad++;
    end
    if (cfg_valid && cfg_ready) begin
      if (ngot < 32) got[ngot] = cfg_data;
      ngot++;
      hold = 0;
    end else if (cfg_valid) begin
      hold = 1;
      hold_d = cfg_data;
    end else hold = 0;
  end

  int nchk = 0, nfail = 0;
  bit finished = 0;
  bit exp_iso [2] = '{0, 0};
  int exp_slot [2] = '{0, 0};

  function automatic logic [7:0] img_byte(input int a);
    return 8'((a * 13 + 7) & 255);
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
    end
  endtask

  task automatic host_byte(input int a, output int refused);
    host_mem_wr = 1; host_mem_addr = 8'(a); host_mem_data = img_byte(a);
    #1 refused = (host_mem_ok && mem_we) ? 0 : 1;
    @(negedge clk);
    host_mem_wr = 0;
  endtask

  task automatic host_slot(input int s, input int st, input int ln);
    host_tbl_wr = 1; host_tbl_slot = 2'(s); host_tbl_start = 8'(st); host_tbl_len = 8'(ln);
    @(negedge clk);
    host_tbl_wr = 0;
  endtask

  task automatic cmd(input bit drop, input int area, input int slot);
    cpu_cmd = {drop, 2'(slot), 1'(area)};
    cpu_cmd_wr = 1;
    @(negedge clk);
    cpu_cmd_wr = 0;
  endtask

  task automatic clr(input logic [1:0] bits);
    cpu_clr = bits; cpu_clr_wr = 1;
    @(negedge clk);
    cpu_clr_wr = 0;
  endtask

  task automatic wait_done();
    int n = 0;
    while (!st_done && n < 2000) begin @(negedge clk); n++; end
  endtask

  task automatic check_bytes(input string req, input int st, input int ln);
    int bad = 0;
    chk({req, " byte count"}, ngot, ln);
    for (int i = 0; i < ln && i < 32; i++)
      if (got[i] != img_byte((st + i) & 255)) bad++;
    chk({req, " byte order/content mismatches"}, bad, 0);
  endtask

  // watchdog
  initial begin
    #(4 * 150000);
    nchk++; nfail++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    int refused;
    int nv0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 busy", st_busy, 0);
    chk("R1 done/irq/error", {st_done, irq, st_error}, 0);
    chk("R1 iso_en", iso_en, 0);
    chk("R1 cfg_valid/mem_we", {cfg_valid, mem_we}, 0);
    rst_n = 1;
    @(negedge clk);
    chk("R1 after release", {st_busy, st_done, irq, st_error, cfg_valid}, 0);

    // load phase: R2 accepted writes, R3 table load
    refused = 0;
    for (int s = 0; s < 4; s++)
      for (int i = 0; i < S_LEN[s]; i++) begin
        int r;
        host_byte(S_START[s] + i, r);
        refused += r;
      end
    chk("R2 host writes accepted in load mode", refused, 0);
    for (int s = 0; s < 4; s++) host_slot(s, S_START[s], S_LEN[s]);
    mode_load = 0;
    @(negedge clk);

    // vector table walk: R4 R5 R6 R9 R11
    for (int v = 0; v < NV; v++) begin
      automatic int ar = int'(VEC[v][10]);
      automatic int sl = int'(VEC[v][9:8]);
      rdy_pat = VEC[v][7:0];
      ngot = 0; nstall = 0; narea_bad = 0; want_area = 1'(ar);
      cmd(0, ar, sl);
      chk("R6 busy after fill", st_busy, 1);
      chk("R6 target isolated", iso_en[ar], 0);
      wait_done();
      check_bytes("R4", S_START[sl], S_LEN[sl]);
      chk("R4 stall stability", nstall, 0);
      chk("R4 cfg_area", narea_bad, 0);
      chk("R5 done/irq/busy", {st_done, irq, st_busy}, 3'b110);
      chk("R5 iso_en target", iso_en[ar], 1);
      chk("R5 area_slot", int'(area_slot[ar*SLOT_W +: SLOT_W]), sl);
      chk("R11 other area", iso_en[1-ar], exp_iso[1-ar]);
      exp_iso[ar] = 1; exp_slot[ar] = sl;
      clr(2'b01);
      chk("R9 done cleared", {st_done, irq}, 0);
    end

    // R3: table write in run mode ignored
    host_slot(1, 8'h80, 3);
    rdy_pat = 8'hFF; ngot = 0; want_area = 1'b1;
    cmd(0, 1, 1);
    wait_done();
    check_bytes("R3 run-mode table write ignored", S_START[1], S_LEN[1]);
    clr(2'b01);

    // R2 refused in run mode while idle
    begin
      int r;
      host_byte(8'h11, r);
      chk("R2 refused in run mode", r, 1);
    end

    // R7 reject while busy, R2 refuse host write while busy
    rdy_pat = 8'b0100_1001; ngot = 0; want_area = 1'b0;
    cmd(0, 0, 2);
    cmd(0, 1, 0);
    chk("R7 error after busy command", st_error, 1);
    chk("R7 still busy", st_busy, 1);
    mode_load = 1;
    host_mem_wr = 1; host_mem_addr = 8'h81; host_mem_data = 8'h00;
    #1 chk("R2 host write refused while busy", {host_mem_ok, mem_we}, 0);
    @(negedge clk);
    host_mem_wr = 0; mode_load = 0;
    wait_done();
    check_bytes("R7/R2 only first stream, memory intact", S_START[2], S_LEN[2]);
    chk("R7 other area untouched", {iso_en[1], area_slot[SLOT_W +: SLOT_W]}, {1'b1, 2'd1});

    // R9 clear semantics
    clr(2'b00);
    chk("R9 zero write keeps flags", {st_done, st_error}, 2'b11);
    clr(2'b10);
    chk("R9 error clear only", {st_done, st_error}, 2'b10);
    clr(2'b01);
    chk("R9 done clear", {st_done, irq}, 0);

    // R7 reject in load mode
    mode_load = 1;
    nv0 = nvalid;
    cmd(0, 0, 0);
    chk("R7 rejected in load mode", {st_error, st_busy}, 2'b10);
    repeat (6) @(negedge clk);
    chk("R7 nothing streamed", nvalid - nv0, 0);
    clr(2'b10);
    mode_load = 0;
    @(negedge clk);

    // R8 release area 0
    nv0 = nvalid;
    cmd(1, 0, 0);
    chk("R8 area released", iso_en[0], 0);
    chk("R11 area1 kept", iso_en[1], 1);
    chk("R8 no busy/done", {st_busy, st_done}, 0);
    repeat (4) @(negedge clk);
    chk("R8 no stream", nvalid - nv0, 0);

    // R10 zero-length image
    nv0 = nvalid;
    cmd(0, 0, 3);
    chk("R10 done/busy", {st_done, st_busy}, 2'b10);
    chk("R10 area loaded", {iso_en[0], area_slot[1:0]}, {1'b1, 2'd3});
    repeat (4) @(negedge clk);
    chk("R10 no stream", nvalid - nv0, 0);

    summary();
  end

endmodule